// File: doc/BRIEF.md
# FM Synthesiser Register Write Pacer

The pacer sits between a CPU's I/O write path and the address and data ports of an FM sound synthesiser. Each write request carries one byte and a tag that says whether the byte is a register index (an address write) or a register value (a data write). The synthesiser can only accept a new access after a recovery time, and that time depends on the kind of access that came before it. A short wait follows an address write. A much longer wait follows a data write.

A down-counter is loaded with the recovery interval that belongs to the access just forwarded. While the counter is non-zero, or while a request is already waiting, the `ready` output is low. A request that arrives while `ready` is low is captured in a single holding slot. It is sent on by itself on the first cycle the interval has elapsed, so the requester stalls rather than losing the write. A data write that is forwarded before any address write since reset is still passed through, but it is flagged as a sequence error.

The recovery intervals are given in nanoseconds together with the clock frequency in kHz. They are turned into whole clock cycles by rounding up.

Top module: `fm_write_pacer`

## Requirements
- R1: After reset, `ready` is 1, `out_strobe` is 0 and `seq_err` is 0. `out_strobe` stays 0 for as long as no request is presented.
- R2: A request sampled on a clock edge with `req_valid`=1 and `ready`=1 is forwarded on that edge. `out_strobe` is 1 for exactly the following cycle, with `out_byte` equal to `req_byte` and `out_is_data` equal to `req_is_data`. The tag encoding is 0 = address write, 1 = data write.
- R3: After an address write is forwarded, `ready` is low for exactly ADDR_CYC-1 cycles. Two strobes are never closer than ADDR_CYC cycles when the first one is an address write.
- R4: After a data write is forwarded, `ready` is low for exactly DATA_CYC-1 cycles. Two strobes are never closer than DATA_CYC cycles when the first one is a data write.
- R5: A request presented for a single cycle while `ready` is low is held. It is forwarded with its own byte and tag exactly ADDR_CYC (or DATA_CYC) cycles after the previous strobe, with no further action from the requester.
- R6: While a request is held, `ready` stays low. Any other request presented in that time is dropped: it is never forwarded, and the held byte is not overwritten.
- R7: A data write forwarded before any address write has been forwarded since reset raises `seq_err` for the single cycle of its strobe. A data write forwarded after an address write leaves `seq_err` at 0.
- R8: ADDR_CYC = ceil(ADDR_NS·CLK_KHZ/10^6) and DATA_CYC = ceil(DATA_NS·CLK_KHZ/10^6), each raised to at least 2. The defaults give 13 and 85.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request, one cycle per request |
| req_is_data | input | 1 | Request tag: 0 address write, 1 data write |
| req_byte | input | BYTE_W | Byte to write |
| ready | output | 1 | High when a request would be forwarded at once |
| out_strobe | output | 1 | One-cycle write strobe to the synthesiser |
| out_byte | output | BYTE_W | Forwarded byte |
| out_is_data | output | 1 | Forwarded tag: 0 address port, 1 data port |
| seq_err | output | 1 | Data write forwarded without a prior address write |

## Verification
The bench uses the default parameters: a 3580 kHz clock, 3400 ns after an address write and 23500 ns after a data write. These give intervals of 13 and 85 cycles. Both intervals are long enough that a request can be held during an address wait while a second request arrives to test that it is dropped. They are also short enough to measure every stall cycle exactly. The bench checks the interval values against its own rounding formula, and checks the sequence error flag both straight after reset and after an address write.

// File: rtl/fm_pacer_pkg.sv
package fm_pacer_pkg;

  typedef enum logic {
    ACC_ADDR = 1'b0,
    ACC_DATA = 1'b1
  } acc_kind_e;

  // Recovery time in ns at a clock of khz kHz, rounded up to whole cycles, minimum 2
  function automatic int ceil_cycles(input int ns, input int khz);
    longint prod;
    longint cyc;
    prod = longint'(ns) * longint'(khz);
    cyc  = (prod + 64'sd999999) / 64'sd1000000;
    if (cyc < 64'sd2) cyc = 64'sd2;
    return int'(cyc);
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fm_pacer_timer.sv
module fm_pacer_timer
  import fm_pacer_pkg::*;
#(
  parameter int ADDR_CYC = 13,
  parameter int DATA_CYC = 85
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  acc_kind_e kind,
  output logic      zero
);
  localparam int CNT_W = $clog2(max_int(ADDR_CYC, DATA_CYC));
  localparam logic [CNT_W-1:0] ADDR_LOAD = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] DATA_LOAD = CNT_W'(DATA_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (kind == ACC_DATA) ? DATA_LOAD : ADDR_LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/fm_pacer_hold.sv
module fm_pacer_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic         full,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (capture) begin
      full <= 1'b1;
      q    <= d;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/fm_pacer_seq.sv
module fm_pacer_seq
  import fm_pacer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  acc_kind_e kind,
  output logic      err_now
);
  logic addr_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                          addr_seen <= 1'b0;
    else if (fire && kind == ACC_ADDR)   addr_seen <= 1'b1;
  end

  assign err_now = fire && (kind == ACC_DATA) && !addr_seen;
endmodule

// File: rtl/fm_write_pacer.sv
module fm_write_pacer
  import fm_pacer_pkg::*;
#(
  parameter int CLK_KHZ = 3580,
  parameter int ADDR_NS = 3400,
  parameter int DATA_NS = 23500,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_data,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              ready,
  output logic              out_strobe,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_is_data,
  output logic              seq_err
);
  localparam int ADDR_CYC = ceil_cycles(ADDR_NS, CLK_KHZ);
  localparam int DATA_CYC = ceil_cycles(DATA_NS, CLK_KHZ);
  localparam int REQ_W    = BYTE_W + 1;

  // Named internal events, visible to the bound checker
  logic              tmr_zero;
  logic              hold_full;
  logic [REQ_W-1:0]  hold_q;
  logic [REQ_W-1:0]  req_vec;
  logic [REQ_W-1:0]  fire_vec;
  logic              fire_direct;
  logic              fire_hold;
  logic              fire;
  logic              capture;
  logic              err_now;
  acc_kind_e         fire_kind;

  assign req_vec     = {req_is_data, req_byte};
  assign ready       = tmr_zero && !hold_full;
  assign fire_hold   = tmr_zero && hold_full;
  assign fire_direct = ready && req_valid;
  assign fire        = fire_hold || fire_direct;
  assign capture     = req_valid && !ready && !hold_full;
  assign fire_vec    = hold_full ? hold_q : req_vec;
  assign fire_kind   = acc_kind_e'(fire_vec[BYTE_W]);

  fm_pacer_timer #(
    .ADDR_CYC(ADDR_CYC),
    .DATA_CYC(DATA_CYC)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (fire),
    .kind (fire_kind),
    .zero (tmr_zero)
  );

  fm_pacer_hold #(
    .W(REQ_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .drain  (fire_hold),
    .d      (req_vec),
    .full   (hold_full),
    .q      (hold_q)
  );

  fm_pacer_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .kind   (fire_kind),
    .err_now(err_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_strobe  <= 1'b0;
      out_byte    <= '0;
      out_is_data <= 1'b0;
      seq_err     <= 1'b0;
    end else begin
      out_strobe <= fire;
      seq_err    <= err_now;
      if (fire) begin
        out_byte    <= fire_vec[BYTE_W-1:0];
        out_is_data <= fire_vec[BYTE_W];
      end
    end
  end
endmodule

// File: rtl/fm_write_pacer_chk.sv
module fm_write_pacer_chk
  import fm_pacer_pkg::*;
#(
  parameter int CLK_KHZ = 3580,
  parameter int ADDR_NS = 3400,
  parameter int DATA_NS = 23500,
  parameter int BYTE_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_is_data,
  input logic [BYTE_W-1:0] req_byte,
  input logic              ready,
  input logic              out_strobe,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_is_data,
  input logic              seq_err,
  input logic              hold_full,
  input logic              tmr_zero
);
  localparam int ADDR_CYC = ceil_cycles(ADDR_NS, CLK_KHZ);
  localparam int DATA_CYC = ceil_cycles(DATA_NS, CLK_KHZ);

  int   gap;
  logic seen;
  logic last_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= 0;
      seen      <= 1'b0;
      last_data <= 1'b0;
    end else if (out_strobe) begin
      gap       <= 1;
      seen      <= 1'b1;
      last_data <= out_is_data;
    end else if (gap < DATA_CYC) begin
      gap <= gap + 1;
    end
  end

  // R3 / R4: strobe spacing depends on the kind of the previous strobe
  a_r3_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && seen) |-> (gap >= (last_data ? DATA_CYC : ADDR_CYC)));

  // R2: an accepted request appears at the outputs on the next cycle
  a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> (out_strobe && out_byte == $past(req_byte)
                              && out_is_data == $past(req_is_data)));

  // R5: a held request leaves the slot once the interval ends
  a_r5_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && tmr_zero) |=> (out_strobe && !hold_full));

  // R6: never two strobes back to back
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);

  // R7: the sequence flag only accompanies a forwarded data write
  a_r7_seq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (out_strobe && out_is_data));
endmodule

bind fm_write_pacer fm_write_pacer_chk #(
  .CLK_KHZ(CLK_KHZ),
  .ADDR_NS(ADDR_NS),
  .DATA_NS(DATA_NS),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_is_data(req_is_data),
  .req_byte   (req_byte),
  .ready      (ready),
  .out_strobe (out_strobe),
  .out_byte   (out_byte),
  .out_is_data(out_is_data),
  .seq_err    (seq_err),
  .hold_full  (hold_full),
  .tmr_zero   (tmr_zero)
);

// File: tb/fm_write_pacer_bench.sv
module fm_write_pacer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ  = 3580;
  localparam int A_NS = 3400;
  localparam int D_NS = 23500;

  // Independent restatement of R8: ceil(a/b) as (a-1)/b + 1, minimum 2
  function automatic int want_cycles(input int ns);
    longint p;
    int c;
    p = longint'(ns) * longint'(KHZ);
    c = int'((p - 1) / 1000000 + 1);
    return (c < 2) ? 2 : c;
  endfunction

  localparam int A_CYC = want_cycles(A_NS);
  localparam int D_CYC = want_cycles(D_NS);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_is_data = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       ready, out_strobe, out_is_data, seq_err;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_write_pacer u_fm_write_pacer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_data(req_is_data),
    .req_byte(req_byte), .ready(ready), .out_strobe(out_strobe),
    .out_byte(out_byte), .out_is_data(out_is_data), .seq_err(seq_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  // Called at a negedge; returns at the next negedge with the request removed
  task automatic send(input logic is_data, input logic [7:0] b);
    req_valid = 1'b1;
    req_is_data = is_data;
    req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic count_low(output int low);
    low = 0;
    while (!ready) begin
      low++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int strobes = 0;
    do_reset();
    chk("R1 ready after reset", ready, 1);
    chk("R1 seq_err after reset", seq_err, 0);
    repeat (10) begin
      if (out_strobe) strobes++;
      @(negedge clk);
    end
    chk("R1 no strobe while idle", strobes, 0);
    chk("R8 address interval", A_CYC, 13);
    chk("R8 data interval", D_CYC, 85);
  endtask

  task automatic t_intervals();
    int low;
    do_reset();
    send(1'b0, 8'h20);
    chk("R2 strobe on address", out_strobe, 1);
    chk("R2 address byte", out_byte, 8'h20);
    chk("R2 address tag", out_is_data, 0);
    count_low(low);
    chk("R3 ready low after address", low, A_CYC - 1);
    send(1'b1, 8'hA5);
    chk("R2 strobe on data", out_strobe, 1);
    chk("R2 data byte", out_byte, 8'hA5);
    chk("R2 data tag", out_is_data, 1);
    chk("R7 no error after address", seq_err, 0);
    @(negedge clk);
    chk("R2 strobe lasts one cycle", out_strobe, 0);
    count_low(low);
    chk("R4 ready low after data", low, D_CYC - 2);
    send(1'b0, 8'h21);
    count_low(low);
    chk("R3 address after data", low, A_CYC - 1);
  endtask

  task automatic t_hold();
    int gap;
    int extra = 0;
    do_reset();
    send(1'b0, 8'h30);
    // first strobe is visible now; present a data request while stalled
    req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'hC3;
    @(negedge clk);
    gap = 1;
    chk("R6 ready low while holding", ready, 0);
    req_valid = 1'b1; req_is_data = 1'b0; req_byte = 8'h5A;
    @(negedge clk);
    gap = 2;
    req_valid = 1'b0;
    while (!out_strobe) begin
      @(negedge clk);
      gap++;
    end
    chk("R5 held request spacing", gap, A_CYC);
    chk("R5 held byte", out_byte, 8'hC3);
    chk("R5 held tag", out_is_data, 1);
    @(negedge clk);
    repeat (D_CYC + 5) begin
      if (out_strobe) extra++;
      @(negedge clk);
    end
    chk("R6 dropped request never forwarded", extra, 0);
  endtask

  task automatic t_sequence();
    do_reset();
    send(1'b1, 8'h11);
    chk("R7 data without address forwarded", out_strobe, 1);
    chk("R7 error flag raised", seq_err, 1);
    @(negedge clk);
    chk("R7 error flag one cycle", seq_err, 0);
    wait_ready();
    send(1'b0, 8'h02);
    chk("R7 no flag on address", seq_err, 0);
    wait_ready();
    send(1'b1, 8'h33);
    chk("R7 no flag after address", seq_err, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_intervals();
    t_hold();
    t_sequence();
    finish_run();
  end
endmodule